// File: doc/BRIEF.md
# Pre/Post Reference-Trigger Record Capture

The block turns a free-running stream of input words into one framed record. A start pulse arms it. From the next clock on it writes one word per cycle into a circular buffer whose wrap length is the programmed record length. It then waits for a reference event, which is either a selected edge on an external line or a masked match of the input word against a programmed value. A reference event is only honoured once at least the programmed number of pre-event words has been stored. After that, the block stores the remaining post-event words and stops.

When the record is complete, the block raises a done flag and holds it. It also reports two buffer addresses: the slot that holds the first word of the record and the slot that holds the reference-event word. A reader walks the buffer from the first-word address, wrapping at the record length, to get the record in time order. The buffer read port has one cycle of latency. A new start pulse after completion re-arms the block.

Top module: `ref_trig_capture`

## Requirements
- R1: After reset `done_o` is 0. A `start_i` pulse seen while idle or done latches `cfg_len_i` and `cfg_pre_i` and begins a capture. `done_o` is 0 in the cycle after that start.
- R2: Capture cycle c (c = 1 is the first clock after the start clock) writes `smp_i` to buffer address (c-1) mod L, where L is the latched record length.
- R3: A reference event in capture cycle c is ignored when fewer than P words were written before that cycle (c-1 < P). P is the latched pre-event count.
- R4: Edge source (`cfg_src_pat_i`=0): a 0-to-1 transition of `ref_edge_i` is the reference event when `cfg_fall_i`=0, and a 1-to-0 transition is the event when `cfg_fall_i`=1.
- R5: Pattern source (`cfg_src_pat_i`=1): the input matches when every bit with `cfg_mask_i`=0 equals `cfg_pat_i`; bits with mask 1 are don't-care. The event is the first cycle of a match, so it lasts one cycle.
- R6: When the event is accepted in cycle T, the words of cycles T to T+L-P-1 are written and no others. If L-P = 0, nothing is written in cycle T.
- R7: `done_o` rises one cycle after the last write, or after the clock of T when L-P = 0. It stays high, with no further writes, until the next start.
- R8: At done, `trig_addr_o` = (T-1) mod L and `first_addr_o` = (T-1-P) mod L. Buffer slot (first+k) mod L holds the word of cycle T-P+k.
- R9: `start_i` has no effect while a capture is in progress.
- R10: `rd_data_o` presents the word at `rd_addr_i` one clock after the address is applied.
- R11: Every record length from 1 to DEPTH and every pre-event count from 0 to L is supported, including L=1, P=0 and P=L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | DW | Input data word, one per cycle |
| start_i | input | 1 | Start pulse that arms a capture |
| ref_edge_i | input | 1 | External reference line |
| cfg_src_pat_i | input | 1 | 1 selects the pattern source, 0 the edge source |
| cfg_fall_i | input | 1 | Edge polarity, 1 = falling |
| cfg_pat_i | input | DW | Compare value |
| cfg_mask_i | input | DW | Don't-care mask, 1 = ignore bit |
| cfg_len_i | input | LW | Record length L |
| cfg_pre_i | input | LW | Pre-event word count P |
| rd_addr_i | input | AW | Buffer read address |
| rd_data_o | output | DW | Buffer read data, one cycle latency |
| done_o | output | 1 | Record complete |
| trig_addr_o | output | AW | Slot holding the reference-event word |
| first_addr_o | output | AW | Slot holding the oldest word of the record |

## Verification
The assertions assume that the configuration is legal, meaning 1 ≤ L ≤ DEPTH and P ≤ L. They also assume that the compare value and mask stay steady while a capture is running, so each match produces a single event. The stimulus sets every configuration before the start pulse and holds it until the record has been read back. It feeds the cycle index as the data word, so each pattern vector matches in exactly one chosen cycle, or starts one contiguous run of matches. Each edge is a single isolated pulse, driven away from the idle level for that polarity.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_st_e;
endpackage

// File: rtl/rtc_trig.sv
module rtc_trig #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_i,
  input  logic          edge_i,
  input  logic          src_pat_i,
  input  logic          fall_i,
  input  logic [DW-1:0] pat_i,
  input  logic [DW-1:0] mask_i,
  output logic          trig_o
);
  logic edge_q, hit_q, hit, edge_ev, pat_ev;

  always_comb begin
    hit     = (((smp_i ^ pat_i) & ~mask_i) == '0);
    edge_ev = fall_i ? (edge_q & ~edge_i) : (edge_i & ~edge_q);
    pat_ev  = hit & ~hit_q;
    trig_o  = src_pat_i ? pat_ev : edge_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      edge_q <= edge_i;
      hit_q  <= hit;
    end
  end

  // R5: with steady compare settings a pattern event never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pat_i && trig_o) ##1 (src_pat_i && $stable(pat_i) && $stable(mask_i))
      |-> !trig_o);

  // R4: an edge event means the line differs from its previous level
  a_r4_edge_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_pat_i && trig_o) |-> (edge_i != edge_q));
endmodule

// File: rtl/rtc_buf.sv
module rtc_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          trig_i,
  input  logic [LW-1:0] len_i,
  input  logic [LW-1:0] pre_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          done_o,
  output logic [AW-1:0] trig_addr_o,
  output logic [AW-1:0] first_addr_o
);
  cap_st_e       st_q, st_n;
  logic [LW-1:0] wptr_q, wptr_n, wcnt_q, wcnt_n, pcnt_q, pcnt_n;
  logic [LW-1:0] len_q, pre_q, post_q;
  logic [LW-1:0] trig_a_q, first_a_q, wptr_inc, first_calc;
  logic          cfg_ld, acc;

  always_comb begin
    wptr_inc   = (wptr_q + 1'b1 == len_q) ? '0 : wptr_q + 1'b1;
    first_calc = (wptr_q >= pre_q) ? (wptr_q - pre_q) : (wptr_q + len_q - pre_q);
    st_n   = st_q;
    wptr_n = wptr_q;
    wcnt_n = wcnt_q;
    pcnt_n = pcnt_q;
    we_o   = 1'b0;
    cfg_ld = 1'b0;
    acc    = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_n   = ST_PRE;
          wptr_n = '0;
          wcnt_n = '0;
          pcnt_n = '0;
          cfg_ld = 1'b1;
        end
      end
      ST_PRE: begin
        if (trig_i && (wcnt_q >= pre_q)) begin
          acc = 1'b1;
          if (post_q == '0) begin
            st_n = ST_DONE;
          end else begin
            we_o   = 1'b1;
            wptr_n = wptr_inc;
            pcnt_n = LW'(1);
            st_n   = (post_q == LW'(1)) ? ST_DONE : ST_POST;
          end
        end else begin
          we_o   = 1'b1;
          wptr_n = wptr_inc;
          if (wcnt_q != len_q) wcnt_n = wcnt_q + 1'b1;
        end
      end
      ST_POST: begin
        we_o   = 1'b1;
        wptr_n = wptr_inc;
        pcnt_n = pcnt_q + 1'b1;
        if (pcnt_q + 1'b1 == post_q) st_n = ST_DONE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wptr_q <= '0;
      wcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      st_q   <= st_n;
      wptr_q <= wptr_n;
      wcnt_q <= wcnt_n;
      pcnt_q <= pcnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      pre_q  <= '0;
      post_q <= '0;
    end else if (cfg_ld) begin
      len_q  <= len_i;
      pre_q  <= pre_i;
      post_q <= len_i - pre_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_a_q  <= '0;
      first_a_q <= '0;
    end else if (acc) begin
      trig_a_q  <= wptr_q;
      first_a_q <= first_calc;
    end
  end

  assign waddr_o      = wptr_q[AW-1:0];
  assign done_o       = (st_q == ST_DONE);
  assign trig_addr_o  = trig_a_q[AW-1:0];
  assign first_addr_o = first_a_q[AW-1:0];

  a_r2_wptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (wptr_q < len_q));

  a_r3_hold_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRE && wcnt_q < pre_q) |=> (st_q == ST_PRE));

  a_r6_post_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST) |-> (pcnt_q < post_q));

  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(trig_addr_o) && $stable(first_addr_o)));

  a_r7_no_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !we_o);

  a_r8_first_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (first_a_q < len_q && trig_a_q < len_q));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST && start_i) |=> (st_q == ST_POST || st_q == ST_DONE));
endmodule

// File: rtl/ref_trig_capture.sv
module ref_trig_capture #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_i,
  input  logic          start_i,
  input  logic          ref_edge_i,
  input  logic          cfg_src_pat_i,
  input  logic          cfg_fall_i,
  input  logic [DW-1:0] cfg_pat_i,
  input  logic [DW-1:0] cfg_mask_i,
  input  logic [LW-1:0] cfg_len_i,
  input  logic [LW-1:0] cfg_pre_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic [AW-1:0] trig_addr_o,
  output logic [AW-1:0] first_addr_o
);
  logic          ref_ev, we;
  logic [AW-1:0] waddr;

  rtc_trig #(.DW(DW)) u_trig (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .edge_i(ref_edge_i),
    .src_pat_i(cfg_src_pat_i), .fall_i(cfg_fall_i), .pat_i(cfg_pat_i),
    .mask_i(cfg_mask_i), .trig_o(ref_ev)
  );

  rtc_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(ref_ev),
    .len_i(cfg_len_i), .pre_i(cfg_pre_i), .we_o(we), .waddr_o(waddr),
    .done_o(done_o), .trig_addr_o(trig_addr_o), .first_addr_o(first_addr_o)
  );

  rtc_buf #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(smp_i),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: tb/sim_ref_trig_capture.sv
module sim_ref_trig_capture;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  typedef struct packed {
    int       len;
    int       pre;
    bit       src;
    bit       fall;
    bit [7:0] pat;
    bit [7:0] mask;
    int       t1;
    int       t2;
    int       ta;
  } vec_t;

  // len, pre, src, fall, pat, mask, edge pulse 1, edge pulse 2, accepted cycle
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8,  3,  1'b0, 1'b0, 8'h00, 8'h00, 10, 0,  10},  // R4 rising, mid split
    '{8,  0,  1'b0, 1'b0, 8'h00, 8'h00, 1,  0,  1 },  // R11 P=0
    '{8,  8,  1'b0, 1'b0, 8'h00, 8'h00, 5,  20, 20},  // R3 early ignored, R11 P=L
    '{1,  1,  1'b0, 1'b0, 8'h00, 8'h00, 3,  0,  3 },  // R11 L=1, P=L
    '{1,  0,  1'b0, 1'b1, 8'h00, 8'h00, 4,  0,  4 },  // R4 falling, L=1 P=0
    '{16, 5,  1'b1, 1'b0, 8'd30, 8'h00, 0,  0,  30},  // R5 exact match
    '{12, 4,  1'b1, 1'b0, 8'h50, 8'h0F, 0,  0,  80},  // R5 masked match
    '{16, 10, 1'b0, 1'b0, 8'h00, 8'h00, 6,  15, 15},  // R3 early ignored
    '{16, 16, 1'b0, 1'b0, 8'h00, 8'h00, 17, 0,  17}   // R11 full pre
  };

  logic          clk, rst_n;
  logic [DW-1:0] smp_i, cfg_pat_i, cfg_mask_i, rd_data_o;
  logic          start_i, ref_edge_i, cfg_src_pat_i, cfg_fall_i, done_o;
  logic [LW-1:0] cfg_len_i, cfg_pre_i;
  logic [AW-1:0] rd_addr_i, trig_addr_o, first_addr_o;

  int errors = 0;
  int checks = 0;

  ref_trig_capture #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .start_i(start_i),
    .ref_edge_i(ref_edge_i), .cfg_src_pat_i(cfg_src_pat_i), .cfg_fall_i(cfg_fall_i),
    .cfg_pat_i(cfg_pat_i), .cfg_mask_i(cfg_mask_i), .cfg_len_i(cfg_len_i),
    .cfg_pre_i(cfg_pre_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .trig_addr_o(trig_addr_o), .first_addr_o(first_addr_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int restart_c);
    int  post, done_at, exp_done, bad, first_e, trig_e;
    bit  idle_lvl;
    post     = v.len - v.pre;
    exp_done = (post == 0) ? v.ta : v.ta + post - 1;
    idle_lvl = v.fall;
    @(negedge clk);
    smp_i         = '0;
    ref_edge_i    = idle_lvl;
    cfg_src_pat_i = v.src;
    cfg_fall_i    = v.fall;
    cfg_pat_i     = v.pat;
    cfg_mask_i    = v.mask;
    cfg_len_i     = LW'(v.len);
    cfg_pre_i     = LW'(v.pre);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R1 done low after start", int'(done_o), 0);
    done_at = -1;
    for (int c = 1; c <= 300 && done_at < 0; c++) begin
      smp_i      = DW'(c);
      ref_edge_i = (c == v.t1 || c == v.t2) ? ~idle_lvl : idle_lvl;
      start_i    = (c == restart_c);
      @(negedge clk);
      start_i = 1'b0;
      if (done_o) done_at = c;
    end
    chk(done_at == exp_done, "R6 done cycle", done_at, exp_done);
    smp_i      = 8'hEE;
    ref_edge_i = idle_lvl;
    trig_e  = (v.ta - 1) % v.len;
    first_e = (v.ta - 1 - v.pre) % v.len;
    chk(int'(trig_addr_o) == trig_e, "R8 trig addr", int'(trig_addr_o), trig_e);
    chk(int'(first_addr_o) == first_e, "R8 first addr", int'(first_addr_o), first_e);
    bad = 0;
    for (int k = 0; k < v.len; k++) begin
      rd_addr_i = AW'((first_e + k) % v.len);
      @(negedge clk);
      if (rd_data_o != DW'(v.ta - v.pre + k)) begin
        bad++;
        $display("FAIL R2 R10 slot %0d actual=%0d expected=%0d",
                 (first_e + k) % v.len, rd_data_o, (v.ta - v.pre + k) & 8'hFF);
      end
    end
    checks++;
    if (bad != 0) errors++;
    chk(done_o == 1'b1, "R7 done held", int'(done_o), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    smp_i = '0; start_i = 1'b0; ref_edge_i = 1'b0;
    cfg_src_pat_i = 1'b0; cfg_fall_i = 1'b0; cfg_pat_i = '0; cfg_mask_i = '0;
    cfg_len_i = LW'(8); cfg_pre_i = '0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 reset state", int'(done_o), 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], -1);
    // R9: a start pulse mid-capture must not restart the record
    run_vec(VECS[0], 3);
    run_vec(VECS[0], 12);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule